// File: doc/BRIEF.md
# RC-5 Infrared Frame Encoder

This block serializes one RC-5 remote-control frame onto a single infrared output line. The host places a 5-bit device address, a command of up to 7 bits and a mode select on its inputs, then pulses `send_i`. The encoder assembles a 14-bit frame and emits it most significant bit first. The frame holds two start positions, a toggle bit, the address and the command. Each bit is sent as two equal half-bit slots in bi-phase form.

The toggle bit is kept inside the block. It inverts whenever a frame carries a command different from the previous frame, or when the host asserts `new_key_i`. A held key that is sent again keeps the same toggle value. In extended mode the second start position carries the seventh command bit.

Half-bit timing is counted from a clock-enable tick. Mark slots can be gated with a carrier generated from the clock, and a parameter turns this gating off. `mark_o` gives the unmodulated envelope and `ir_o` the line as it is driven.

Top module: `rc5_ir_encoder`

## Requirements
- R1: A standard frame is sent MSB first as bit 13 down to bit 0 = {1, 1, T, A4..A0, C5..C0}. A is `addr_i` and C is `cmd_i[5:0]`.
- R2: When `extended_i` = 1, frame bit 12 (the second start position) equals `cmd_i[6]` instead of 1.
- R3: Each frame bit takes two half-bit slots of HALF_TICKS `tick_i` pulses each. A 1 is sent as space then mark, and a 0 as mark then space.
- R4: The first frame after reset carries T = 1. A later frame inverts T if its address, effective command or mode differs from the previous accepted frame, or if `new_key_i` = 1. Otherwise T is unchanged.
- R5: In standard mode `cmd_i[6]` has no effect. The frame is unchanged, and the bit does not count as a command change for the toggle decision.
- R6: A `send_i` pulse while `busy_o` = 1 is ignored. No frame follows, and it does not count as the previous frame for R4.
- R7: `busy_o` rises in the cycle after `send_i` is accepted and stays high for exactly 28·HALF_TICKS ticks. `done_o` is high for exactly one cycle: the first cycle with `busy_o` low.
- R8: `mark_o` and `ir_o` are low whenever `busy_o` is low.
- R9: With CARRIER_EN = 1, `ir_o` = `mark_o` AND a carrier. The carrier restarts at each mark run and is high for the first CARRIER_HIGH clocks of every CARRIER_PERIOD clocks. With CARRIER_EN = 0, `ir_o` = `mark_o`.
- R10: After reset `busy_o`, `done_o`, `mark_o` and `ir_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Clock enable for the half-bit timer |
| send_i | input | 1 | Request to send one frame |
| new_key_i | input | 1 | Forces the toggle to invert for this frame |
| extended_i | input | 1 | 1 selects the 7-bit command format |
| addr_i | input | 5 | Device address |
| cmd_i | input | 7 | Command; bit 6 is used in extended mode only |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last half-bit |
| mark_o | output | 1 | Unmodulated mark envelope |
| ir_o | output | 1 | Infrared line, carrier-gated when enabled |

## Verification
The request is taken at clock edge E0, and `busy_o` and the first half-bit level are visible in the cycle that follows. With a tick on every clock, half-bit k holds from edge E0+k·HALF_TICKS until the next half-bit boundary. `done_o` appears in the single cycle after edge E0+28·HALF_TICKS. The bench samples at the falling edge in every cycle of the frame and compares each sample with the level that the expected frame dictates for that cycle. It checks `done_o` at exactly that one cycle and again one cycle later. With gapped ticks the first tick may come up to one tick period late, so the busy length is checked against a window of that size.

// File: rtl/rc5_enc_pkg.sv
// Package: shared constants, frame type and frame assembly for the RC-5 encoder.
// Assumes the fixed 14-bit frame: two start positions, toggle, 5 address, 6 command.
package rc5_enc_pkg;
    localparam int FRAME_BITS = 14;
    localparam int HALVES     = 2 * FRAME_BITS;
    localparam int ADDR_W     = 5;
    localparam int CMD_W      = 7;
    localparam int HIDX_W     = $clog2(HALVES);
    localparam int BPOS_W     = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] rc5_frame_t;
    typedef logic [ADDR_W-1:0]     rc5_addr_t;
    typedef logic [CMD_W-1:0]      rc5_cmd_t;

    // Effective command: bit 6 only counts in extended mode.
    function automatic rc5_cmd_t eff_cmd(input logic ext, input rc5_cmd_t cmd);
        return ext ? cmd : {1'b0, cmd[CMD_W-2:0]};
    endfunction

    // Assemble a frame, MSB first on the line.
    function automatic rc5_frame_t pack_frame(input logic ext, input logic tog,
                                              input rc5_addr_t addr, input rc5_cmd_t cmd);
        logic second_start;
        second_start = ext ? cmd[CMD_W-1] : 1'b1;
        return {1'b1, second_start, tog, addr, cmd[CMD_W-2:0]};
    endfunction
endpackage

// File: rtl/rc5_frame_builder.sv
// Frame builder: on load, latches the frame and decides the toggle bit.
// Assumes load_i is asserted only when the sequencer is idle.
module rc5_frame_builder
    import rc5_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       ext_i,
    input  logic       new_key_i,
    input  rc5_addr_t  addr_i,
    input  rc5_cmd_t   cmd_i,
    output rc5_frame_t frame_o
);
    logic      toggle_q;
    logic      prev_valid_q;
    logic      prev_ext_q;
    rc5_addr_t prev_addr_q;
    rc5_cmd_t  prev_cmd_q;
    rc5_cmd_t  cmd_eff;
    logic      is_new;
    logic      tog_next;

    // Decide whether this request starts a new command.
    always_comb begin
        cmd_eff  = eff_cmd(ext_i, cmd_i);
        is_new   = new_key_i || !prev_valid_q || (addr_i != prev_addr_q)
                   || (cmd_eff != prev_cmd_q) || (ext_i != prev_ext_q);
        tog_next = is_new ? ~toggle_q : toggle_q;
    end

    // Hold the toggle, the previous request and the frame being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle_q     <= 1'b0;
            prev_valid_q <= 1'b0;
            prev_ext_q   <= 1'b0;
            prev_addr_q  <= '0;
            prev_cmd_q   <= '0;
            frame_o      <= '0;
        end else if (load_i) begin
            toggle_q     <= tog_next;
            prev_valid_q <= 1'b1;
            prev_ext_q   <= ext_i;
            prev_addr_q  <= addr_i;
            prev_cmd_q   <= cmd_eff;
            frame_o      <= pack_frame(ext_i, tog_next, addr_i, cmd_i);
        end
    end
endmodule

// File: rtl/rc5_half_timer.sv
// Half-bit timer: counts tick_i pulses while running and flags the last tick of a half-bit.
// Assumes HALF_TICKS >= 2. Clears while not running.
module rc5_half_timer #(
    parameter int HALF_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic half_end_o
);
    localparam int CNT_W = $clog2(HALF_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign half_end_o = run_i && tick_i && (cnt_q == LAST);

    // Count ticks within the current half-bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rc5_carrier_gate.sv
// Carrier gate: modulates the mark envelope with a clock-derived carrier.
// The carrier phase restarts at each mark run. With CARRIER_EN = 0 the envelope passes through.
module rc5_carrier_gate #(
    parameter bit CARRIER_EN     = 1'b1,
    parameter int CARRIER_PERIOD = 1000,
    parameter int CARRIER_HIGH   = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    output logic ir_o
);
    generate
        if (CARRIER_EN) begin : g_carrier
            localparam int CW = $clog2(CARRIER_PERIOD);
            localparam logic [CW-1:0] PLAST = CW'(CARRIER_PERIOD - 1);
            localparam logic [CW-1:0] PHIGH = CW'(CARRIER_HIGH);
            logic [CW-1:0] ph_q;

            // Advance the carrier phase during marks and clear it during spaces.
            always_ff @(posedge clk) begin
                if (!rst_n || !mark_i) begin
                    ph_q <= '0;
                end else begin
                    ph_q <= (ph_q == PLAST) ? '0 : ph_q + 1'b1;
                end
            end
            assign ir_o = mark_i && (ph_q < PHIGH);
        end else begin : g_plain
            assign ir_o = mark_i;
        end
    endgenerate
endmodule

// File: rtl/rc5_ir_encoder.sv
// RC-5 encoder top: accepts a request, sequences 28 half-bits in bi-phase form,
// and reports busy and done. Assumes the inputs are stable in the cycle send_i is high.
module rc5_ir_encoder
    import rc5_enc_pkg::*;
#(
    parameter int HALF_TICKS     = 32,
    parameter bit CARRIER_EN     = 1'b1,
    parameter int CARRIER_PERIOD = 1000,
    parameter int CARRIER_HIGH   = 300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                send_i,
    input  logic                new_key_i,
    input  logic                extended_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [CMD_W-1:0]    cmd_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                mark_o,
    output logic                ir_o
);
    localparam logic [HIDX_W-1:0] LAST_HALF = HIDX_W'(HALVES - 1);
    localparam logic [BPOS_W-1:0] TOP_BIT   = BPOS_W'(FRAME_BITS - 1);

    logic              busy_q;
    logic              done_q;
    logic [HIDX_W-1:0] half_idx_q;
    logic              accept;
    logic              half_end;
    logic [BPOS_W-1:0] bit_pos;
    logic              cur_bit;
    rc5_frame_t        frame_q;

    assign accept = send_i && !busy_q;

    rc5_frame_builder u_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .ext_i     (extended_i),
        .new_key_i (new_key_i),
        .addr_i    (addr_i),
        .cmd_i     (cmd_i),
        .frame_o   (frame_q)
    );

    rc5_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (busy_q),
        .tick_i     (tick_i),
        .half_end_o (half_end)
    );

    // Select the current frame bit and its bi-phase level for this half.
    always_comb begin
        bit_pos = TOP_BIT - half_idx_q[HIDX_W-1:1];
        cur_bit = frame_q[bit_pos];
        mark_o  = busy_q && (half_idx_q[0] ? cur_bit : ~cur_bit);
    end

    // Sequence the half-bits and produce busy and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            half_idx_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q     <= 1'b1;
                half_idx_q <= '0;
            end else if (half_end) begin
                if (half_idx_q == LAST_HALF) begin
                    busy_q     <= 1'b0;
                    done_q     <= 1'b1;
                    half_idx_q <= '0;
                end else begin
                    half_idx_q <= half_idx_q + 1'b1;
                end
            end
        end
    end

    rc5_carrier_gate #(
        .CARRIER_EN     (CARRIER_EN),
        .CARRIER_PERIOD (CARRIER_PERIOD),
        .CARRIER_HIGH   (CARRIER_HIGH)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .mark_i (mark_o),
        .ir_o   (ir_o)
    );

    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/rc5_ir_encoder_chk.sv
// Checker for the RC-5 encoder: temporal properties on its ports and latched frame.
module rc5_ir_encoder_chk
    import rc5_enc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       send_i,
    input logic       busy_i,
    input logic       done_i,
    input logic       mark_i,
    input logic       ir_i,
    input rc5_frame_t frame_i
);
    // R8: the line stays quiet outside a frame.
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (!mark_i && !ir_i));

    // R9: the output can only be high inside a mark.
    p_ir_in_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ir_i |-> mark_i);

    // R7: done lasts one cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    // R7: done follows the fall of busy.
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> ($past(busy_i) && !busy_i));

    // R7: a frame starts only on a request.
    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> $past(send_i));

    // R6: the latched frame holds while a frame is in progress.
    p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(frame_i));
endmodule

bind rc5_ir_encoder rc5_ir_encoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .send_i  (send_i),
    .busy_i  (busy_o),
    .done_i  (done_o),
    .mark_i  (mark_o),
    .ir_i    (ir_o),
    .frame_i (frame_q)
);

// File: tb/tb_rc5_ir_encoder.sv
// Directed bench for the RC-5 encoder. One task per scenario, each checking its own results.
module tb_rc5_ir_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int HT = 4;
    localparam int CP = 3;
    localparam int CH = 1;
    localparam int NCYC = 28 * HT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b1;
    logic send_i = 1'b0;
    logic new_key_i = 1'b0;
    logic extended_i = 1'b0;
    logic [4:0] addr_i = '0;
    logic [6:0] cmd_i = '0;
    logic busy_o, done_o, mark_o, ir_o;
    logic busy_r, done_r, mark_r, ir_r;
    int   tick_div = 1;
    int   tdiv_cnt = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc5_ir_encoder #(.HALF_TICKS(HT), .CARRIER_EN(1'b1), .CARRIER_PERIOD(CP),
                     .CARRIER_HIGH(CH)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .send_i(send_i),
        .new_key_i(new_key_i), .extended_i(extended_i), .addr_i(addr_i),
        .cmd_i(cmd_i), .busy_o(busy_o), .done_o(done_o), .mark_o(mark_o), .ir_o(ir_o));

    rc5_ir_encoder #(.HALF_TICKS(HT), .CARRIER_EN(1'b0), .CARRIER_PERIOD(CP),
                     .CARRIER_HIGH(CH)) dut_raw (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .send_i(send_i),
        .new_key_i(new_key_i), .extended_i(extended_i), .addr_i(addr_i),
        .cmd_i(cmd_i), .busy_o(busy_r), .done_o(done_r), .mark_o(mark_r), .ir_o(ir_r));

    // Tick generator: every clock, or one in tick_div clocks.
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick_i <= 1'b1;
        end else begin
            tdiv_cnt <= (tdiv_cnt == tick_div - 1) ? 0 : tdiv_cnt + 1;
            tick_i   <= (tdiv_cnt == tick_div - 1);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] exp_frame(input logic ext, input logic tog,
                                              input logic [4:0] a, input logic [6:0] c);
        return {1'b1, (ext ? c[6] : 1'b1), tog, a, c[5:0]};
    endfunction

    function automatic logic exp_level(input logic [13:0] f, input int cyc);
        int h;
        logic b;
        h = cyc / HT;
        b = f[13 - h/2];
        return (h % 2 == 0) ? ~b : b;
    endfunction

    // Send one frame and check every cycle of it. inject sends a competing request mid-frame.
    task automatic send_frame(input logic [4:0] a, input logic [6:0] c, input logic ext,
                              input logic nk, input logic tog, input string tag,
                              input bit inject);
        logic [13:0] ef, got;
        int   bad_lvl = 0, bad_raw = 0, bad_busy = 0;
        int   ir_cnt = 0, ir_exp = 0, pos = 0;
        logic lv, prev_lv;
        ef = exp_frame(ext, tog, a, c);
        got = '0;
        prev_lv = 1'b0;
        @(negedge clk);
        addr_i = a; cmd_i = c; extended_i = ext; new_key_i = nk; send_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        send_i = 1'b0; new_key_i = 1'b0;
        for (int cy = 0; cy < NCYC; cy++) begin
            lv = exp_level(ef, cy);
            if (mark_o !== lv) bad_lvl++;
            if (ir_r !== mark_r || mark_r !== lv) bad_raw++;
            if (busy_o !== 1'b1 || done_o !== 1'b0) bad_busy++;
            if ((cy % HT == 0) && ((cy / HT) % 2 == 1)) got[13 - (cy / HT) / 2] = mark_o;
            if (lv) begin
                pos = prev_lv ? pos + 1 : 0;
                if ((pos % CP) < CH) ir_exp++;
            end
            prev_lv = lv;
            if (ir_o === 1'b1) ir_cnt++;
            if (inject && cy == 40) begin
                addr_i = 5'h03; cmd_i = 7'h01; new_key_i = 1'b1; send_i = 1'b1;
            end
            if (inject && cy == 41) begin
                send_i = 1'b0; new_key_i = 1'b0; addr_i = a; cmd_i = c;
            end
            @(negedge clk);
        end
        check(got === ef, tag, got, ef);
        check(bad_lvl == 0, "R3 half-bit levels", bad_lvl, 0);
        check(ir_cnt == ir_exp, "R9 carrier high cycles", ir_cnt, ir_exp);
        check(bad_raw == 0, "R9 carrier disabled passthrough", bad_raw, 0);
        check(bad_busy == 0, "R7 busy held for frame", bad_busy, 0);
        check(done_o === 1'b1 && busy_o === 1'b0, "R7 done after last half",
              {done_o, busy_o}, 2'b10);
        @(negedge clk);
        check(done_o === 1'b0 && mark_o === 1'b0 && ir_o === 1'b0,
              "R8 line idle after frame", {done_o, mark_o, ir_o}, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({busy_o, done_o, mark_o, ir_o} === 4'b0000, "R10 reset outputs",
              {busy_o, done_o, mark_o, ir_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy_o, mark_o, ir_o} === 3'b000, "R8 idle before any request",
              {busy_o, mark_o, ir_o}, 0);
    endtask

    task automatic t_toggle_and_modes();
        send_frame(5'h05, 7'h15, 1'b0, 1'b0, 1'b1, "R1 first standard frame", 1'b0);
        send_frame(5'h05, 7'h15, 1'b0, 1'b0, 1'b1, "R4 repeat keeps toggle", 1'b0);
        send_frame(5'h05, 7'h15, 1'b0, 1'b1, 1'b0, "R4 new key flips toggle", 1'b0);
        send_frame(5'h05, 7'h2A, 1'b0, 1'b0, 1'b1, "R4 command change flips toggle", 1'b0);
        send_frame(5'h05, 7'h6A, 1'b0, 1'b0, 1'b1, "R5 bit 6 ignored in standard", 1'b0);
        send_frame(5'h1F, 7'h55, 1'b1, 1'b0, 1'b0, "R2 extended with C6=1", 1'b0);
        send_frame(5'h1F, 7'h15, 1'b1, 1'b0, 1'b1, "R2 extended with C6=0", 1'b0);
    endtask

    task automatic t_busy_ignore();
        send_frame(5'h1F, 7'h15, 1'b1, 1'b0, 1'b1, "R6 frame with ignored request", 1'b1);
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                if (busy_o !== 1'b0 || mark_o !== 1'b0) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R6 no frame from request while busy", seen, 0);
        end
        send_frame(5'h1F, 7'h15, 1'b1, 1'b0, 1'b1, "R6 ignored request left toggle", 1'b0);
    endtask

    task automatic t_gapped_ticks();
        int len = 0;
        int lo = 3 * (NCYC - 1) + 1;
        int hi = 3 * NCYC;
        tick_div = 3;
        repeat (4) @(negedge clk);
        addr_i = 5'h02; cmd_i = 7'h01; extended_i = 1'b0; send_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        send_i = 1'b0;
        while (busy_o === 1'b1 && len < 2 * hi) begin
            len++;
            @(negedge clk);
        end
        check(len >= lo && len <= hi, "R3 half-bit counted in ticks", len, hi);
        check(done_o === 1'b1, "R7 done with gapped ticks", done_o, 1);
        tick_div = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_toggle_and_modes();
        t_busy_ignore();
        t_gapped_ticks();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule